// File: doc/BRIEF.md
# I2C Master Byte Engine with Automatic Abort

This block is the master side of a two-wire serial bus. It pulls SCL and SDA low through two open-drain enables and reads SDA back. One command starts a whole transaction. The command latches a 7-bit target address, a direction and a byte count. The engine then generates START and sends the address byte. It moves the requested number of data bytes in the chosen direction and finishes with STOP. The SCL period is fixed by a divider parameter. Every bit takes four equal quarter slots of `DIV` clock cycles each.

After each byte it sends, the engine samples the acknowledge bit. If the target leaves SDA high, the engine records a sticky bus-error flag and goes straight to STOP. No further command is needed. An interrupt follows the flag when its enable is set. When receiving, the engine drives the acknowledge bit from the `rx_nack` input. A refusal it sends itself is normal flow control, not an error. Transmit bytes are taken from `tx_data` at the end of the previous byte. Received bytes appear on `rx_data` together with the one-cycle `byte_done` pulse.

Top module: `i2c_byte_master`

## Requirements
- R1: During and after reset, both open-drain enables are low (lines released) and `busy`, `byte_done`, `bus_err` and `irq` are low. Whenever `busy` is low, both enables stay low.
- R2: A `go` seen while idle with `bus_err` low raises `busy` on the next cycle. The engine then produces one START (SDA falls while SCL is high) and sends the address byte MSB first. That byte is `{go_addr, go_read}`, so bit 0 is 1 for a read and 0 for a write. `busy` stays high until the STOP has finished.
- R3: Apart from START and STOP, SDA changes only while SCL is low. Every SCL high period inside a transfer lasts exactly 2*DIV clock cycles.
- R4: In the ninth clock of every byte the engine transmits, it releases SDA. It treats SDA sampled low in that clock as acknowledge.
- R5: In a write, the engine sends `go_len` data bytes after an acknowledged address. Byte j is the `tx_data` value present at the clock edge that raises the previous `byte_done`. When the last byte has been acknowledged, one STOP ends the transfer.
- R6: In a read, the engine clocks in `go_len` bytes MSB first after an acknowledged address. Each byte is on `rx_data` while its `byte_done` is high. In each byte's ninth clock the engine drives SDA low when `rx_nack` is 0 and releases it when `rx_nack` is 1. One STOP follows the last byte.
- R7: If SDA is high in the acknowledge clock of any byte the engine sends, the engine sets `bus_err`. It then issues STOP by itself, sends no further byte, and drops `busy`.
- R8: A refusal the engine drives while receiving never sets `bus_err`.
- R9: `irq` is high only while `bus_err` is high. It follows `bus_err` AND `err_ie` one cycle later.
- R10: `bus_err` stays set until `err_clr` is 1, and `err_clr` then clears it on the next edge. A `go` is ignored while `bus_err` is set or while `busy` is high.
- R11: `byte_done` is a one-cycle pulse at the end of each ninth clock, including the address byte's. With `go_len` = 0, the transfer is only the address byte followed by STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a transfer (sampled when idle and error-free) |
| go_addr | input | 7 | Target address |
| go_read | input | 1 | 1 = read, 0 = write |
| go_len | input | LEN_W | Number of data bytes |
| tx_data | input | 8 | Next byte to transmit |
| rx_nack | input | 1 | 1 = refuse the byte being received |
| err_clr | input | 1 | Clear the bus-error flag |
| err_ie | input | 1 | Bus-error interrupt enable |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Transfer in progress |
| byte_done | output | 1 | End of a ninth clock |
| rx_data | output | 8 | Last received byte |
| bus_err | output | 1 | Sticky missing-acknowledge flag |
| irq | output | 1 | Bus-error interrupt |

## Verification
The assertions assume that SCL follows `scl_oe`, since no other device stretches or drives the clock. They also assume the target moves SDA only while SCL is low, and that `tx_data` and `rx_nack` are stable around the quarter edges where they are used. The bench target drives SDA only right after SCL falls. The bench updates `tx_data` and `rx_nack` half a cycle after each `byte_done`, well before the next load or acknowledge slot. The stimulus sweeps both directions, byte counts 0 to 3, a matching and a mismatched address, and target refusals at every data position. Every byte value is computed in the bench from the address and the byte index.

// File: rtl/i2c_byte_master_pkg.sv
package i2c_byte_master_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BIT   = 2'd2,
    PH_STOP  = 2'd3
  } phase_e;
endpackage

// File: rtl/i2cm_quarter_tick.sv
module i2cm_quarter_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)     cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2cm_shifter.sv
module i2cm_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         shift_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], shift_in};
  end
endmodule

// File: rtl/i2cm_err_flag.sv
module i2cm_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  logic flag_n;
  assign flag_n = set ? 1'b1 : (clr ? 1'b0 : flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_n;
      irq  <= flag_n & ie;
    end
  end

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (flag && ie && !clr) |=> irq);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_byte_master_pkg::*;
#(
  parameter int DIV    = 8,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [6:0]        go_addr,
  input  logic              go_read,
  input  logic [LEN_W-1:0]  go_len,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_nack,
  input  logic              err_clr,
  input  logic              err_ie,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_data,
  output logic              bus_err,
  output logic              irq
);
  localparam int BC_W = $clog2(DATA_W + 1);
  localparam logic [BC_W-1:0] ACK_IDX = BC_W'(DATA_W);

  phase_e            ph, ph_n;
  logic [1:0]        q, q_n;
  logic [BC_W-1:0]   bitcnt, bit_n;
  logic              addr_ph, rd_mode, read_req, ack_ok;
  logic [LEN_W-1:0]  rem;
  logic              scl_r, sda_r, scl_n, sda_n;
  logic              busy_r, done_r;
  logic [DATA_W-1:0] rx_r;

  logic              tick, accept;
  logic              ack_sample, ack_end, bit_shift;
  logic              nack_tx, last_byte, go_stop, bit_drive;
  logic              sh_load, sh_shift;
  logic [DATA_W-1:0] sh_val, sh_q;
  logic              err_set;

  i2cm_quarter_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .run(busy_r), .tick(tick)
  );

  assign accept     = go && (ph == PH_IDLE) && !busy_r && !bus_err;
  assign bit_shift  = tick && (ph == PH_BIT) && (q == 2'd2) && (bitcnt != ACK_IDX);
  assign ack_sample = tick && (ph == PH_BIT) && (q == 2'd2) && (bitcnt == ACK_IDX);
  assign ack_end    = tick && (ph == PH_BIT) && (q == 2'd3) && (bitcnt == ACK_IDX);
  assign nack_tx    = !rd_mode && !ack_ok;
  assign last_byte  = addr_ph ? (rem == '0) : (rem == LEN_W'(1));
  assign go_stop    = nack_tx || last_byte;
  assign err_set    = ack_end && nack_tx;

  always_comb begin
    sh_load  = 1'b0;
    sh_val   = '0;
    sh_shift = 1'b0;
    if (accept) begin
      sh_load = 1'b1;
      sh_val  = DATA_W'({go_addr, go_read});
    end else if (bit_shift) begin
      sh_shift = 1'b1;
    end else if (ack_end && !go_stop && !(addr_ph ? read_req : rd_mode)) begin
      sh_load = 1'b1;
      sh_val  = tx_data;
    end
  end

  i2cm_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .load_val(sh_val),
    .shift(sh_shift), .shift_in(sda_in), .q(sh_q)
  );

  i2cm_err_flag u_err (
    .clk(clk), .rst(rst), .set(err_set), .clr(err_clr), .ie(err_ie),
    .flag(bus_err), .irq(irq)
  );

  // next phase / quarter / bit position on a tick
  always_comb begin
    ph_n  = ph;
    q_n   = q + 2'd1;
    bit_n = bitcnt;
    case (ph)
      PH_IDLE:  q_n = q;
      PH_START: if (q == 2'd3) begin
                  ph_n  = PH_BIT;
                  bit_n = '0;
                end
      PH_BIT:   if (q == 2'd3) begin
                  if (bitcnt != ACK_IDX) bit_n = bitcnt + BC_W'(1);
                  else begin
                    bit_n = '0;
                    if (go_stop) ph_n = PH_STOP;
                  end
                end
      PH_STOP:  if (q == 2'd3) ph_n = PH_IDLE;
      default:  ph_n = PH_IDLE;
    endcase
  end

  // SDA value placed on the bus in the second quarter of a bit
  always_comb begin
    if (bitcnt != ACK_IDX) bit_drive = rd_mode ? 1'b0 : ~sh_q[DATA_W-1];
    else                   bit_drive = rd_mode ? ~rx_nack : 1'b0;
  end

  // line enables for the quarter being entered
  always_comb begin
    scl_n = 1'b0;
    sda_n = 1'b0;
    case (ph_n)
      PH_START: begin
        scl_n = (q_n >= 2'd2);
        sda_n = (q_n >= 2'd1);
      end
      PH_BIT: begin
        scl_n = (q_n < 2'd2);
        sda_n = (q_n == 2'd1) ? bit_drive : sda_r;
      end
      PH_STOP: begin
        scl_n = (q_n < 2'd2);
        sda_n = (q_n == 2'd0) ? sda_r : (q_n != 2'd3);
      end
      default: begin
        scl_n = 1'b0;
        sda_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      q        <= 2'd0;
      bitcnt   <= '0;
      addr_ph  <= 1'b0;
      rd_mode  <= 1'b0;
      read_req <= 1'b0;
      rem      <= '0;
      ack_ok   <= 1'b0;
      scl_r    <= 1'b0;
      sda_r    <= 1'b0;
      busy_r   <= 1'b0;
      done_r   <= 1'b0;
      rx_r     <= '0;
    end else begin
      done_r <= 1'b0;
      if (accept) begin
        ph       <= PH_START;
        q        <= 2'd0;
        bitcnt   <= '0;
        busy_r   <= 1'b1;
        addr_ph  <= 1'b1;
        rd_mode  <= 1'b0;
        read_req <= go_read;
        rem      <= go_len;
      end else if (tick) begin
        ph     <= ph_n;
        q      <= q_n;
        bitcnt <= bit_n;
        scl_r  <= scl_n;
        sda_r  <= sda_n;
        if (ack_sample) ack_ok <= ~sda_in;
        if (ack_end) begin
          done_r <= 1'b1;
          if (rd_mode) rx_r <= sh_q;
          if (!go_stop) begin
            addr_ph <= 1'b0;
            if (addr_ph) rd_mode <= read_req;
            else         rem     <= rem - LEN_W'(1);
          end
        end
        if (ph == PH_STOP && q == 2'd3) busy_r <= 1'b0;
      end
    end
  end

  assign scl_oe    = scl_r;
  assign sda_oe    = sda_r;
  assign busy      = busy_r;
  assign byte_done = done_r;
  assign rx_data   = rx_r;

  assert_lines_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe));
  assert_sda_moves_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_BIT && $past(ph) == PH_BIT && sda_oe != $past(sda_oe))
      |-> (scl_oe && $past(scl_oe)));
  assert_ack_release_R4: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_BIT && !rd_mode && bitcnt == ACK_IDX && q != 2'd0) |-> !sda_oe);
  assert_abort_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_end && !rd_mode && !ack_ok) |=> (ph == PH_STOP && bus_err));
  assert_rx_nack_no_err_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_end && rd_mode && !bus_err && !err_clr) |=> !bus_err);
  assert_go_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    (go && bus_err && !busy) |=> !busy);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done);
endmodule

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
  localparam int DIV = 2;
  localparam int LEN_W = 4;
  localparam logic [6:0] SLV_ADDR = 7'h5A;

  logic clk = 1'b0, rst = 1'b1;
  logic go = 1'b0, go_read = 1'b0, rx_nack = 1'b0, err_clr = 1'b0, err_ie = 1'b0;
  logic [6:0] go_addr = '0;
  logic [LEN_W-1:0] go_len = '0;
  logic [7:0] tx_data = '0;
  logic scl_oe, sda_oe, busy, byte_done, bus_err, irq;
  logic [7:0] rx_data;
  logic slv_oe = 1'b0;
  wire scl = ~scl_oe;
  wire sda = ~(sda_oe | slv_oe);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_start = 0, n_stop = 0, bad_hi = 0;
  int wr_cnt = 0, nack_at = -1, m_ack = 0, m_nack = 0, slv_rd_len = 0;
  logic [7:0] slv_addr_byte = '0;
  logic [7:0] wr_got [16];
  bit finished = 0;

  i2c_byte_master #(.DIV(DIV), .LEN_W(LEN_W), .DATA_W(8)) u_i2c_byte_master (
    .clk(clk), .rst(rst), .go(go), .go_addr(go_addr), .go_read(go_read),
    .go_len(go_len), .tx_data(tx_data), .rx_nack(rx_nack), .err_clr(err_clr),
    .err_ie(err_ie), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .byte_done(byte_done), .rx_data(rx_data),
    .bus_err(bus_err), .irq(irq)
  );

  initial forever #2 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  function automatic logic [7:0] wpat(int a, int j);
    return 8'(a * 3 + j * 59 + 27);
  endfunction
  function automatic logic [7:0] rpat(int j);
    return 8'hC3 ^ 8'(j * 29);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bus event monitors
  initial forever begin @(negedge sda); if (scl === 1'b1) n_start++; end
  initial forever begin @(posedge sda); if (scl === 1'b1) n_stop++; end
  initial forever begin
    int t0, ev;
    @(posedge scl); t0 = cyc; ev = n_start + n_stop;
    @(negedge scl);
    if (ev == n_start + n_stop && cyc - t0 != 2 * DIV) bad_hi++;
  end

  task automatic recv_byte(output logic [7:0] b, output bit stp);
    stp = 0; b = '0;
    for (int i = 7; i >= 0; i--) begin
      @(posedge scl); b[i] = sda;
      if (i == 7) begin
        @(negedge scl or posedge sda);
        if (scl === 1'b1) begin stp = 1; return; end
      end else @(negedge scl);
    end
  endtask

  // behavioural target device
  initial begin
    logic [7:0] b, d;
    bit stp, m;
    forever begin
      do @(negedge sda); while (scl !== 1'b1);
      recv_byte(b, stp);
      if (stp) continue;
      slv_addr_byte = b;
      if (b[7:1] != SLV_ADDR) continue;
      slv_oe = 1'b1; @(negedge scl); slv_oe = 1'b0;
      if (b[0]) begin
        for (int k = 0; k < slv_rd_len; k++) begin
          d = rpat(k);
          for (int i = 7; i >= 0; i--) begin slv_oe = ~d[i]; @(negedge scl); end
          slv_oe = 1'b0; @(posedge scl); m = sda; @(negedge scl);
          if (m) begin m_nack++; break; end
          m_ack++;
        end
      end else begin
        forever begin
          recv_byte(b, stp);
          if (stp) break;
          if (wr_cnt < 16) wr_got[wr_cnt] = b;
          if (wr_cnt != nack_at) slv_oe = 1'b1;
          wr_cnt++;
          @(negedge scl); slv_oe = 1'b0;
        end
      end
    end
  end

  task automatic run_xfer(int addr, bit rd, int len, int nk, bit ie);
    int done_cnt, s0, p0, exp_done, exp_wr, wait_n;
    bit exp_err;
    wr_cnt = 0; nack_at = nk; m_ack = 0; m_nack = 0; slv_rd_len = len;
    err_ie = ie; tx_data = wpat(addr, 0); rx_nack = 1'b0;
    s0 = n_start; p0 = n_stop; done_cnt = 0; bad_hi = 0;
    @(negedge clk);
    go = 1'b1; go_addr = 7'(addr); go_read = rd; go_len = LEN_W'(len);
    @(negedge clk); go = 1'b0;
    chk("R2 busy after go", int'(busy), 1);
    wait_n = 0;
    while (busy && wait_n < 5000) begin
      @(negedge clk); wait_n++;
      if (byte_done) begin
        done_cnt++;
        if (rd && done_cnt >= 2) chk("R6 rx byte", int'(rx_data), int'(rpat(done_cnt - 2)));
        tx_data = wpat(addr, done_cnt);
        rx_nack = (done_cnt == len);
      end
    end
    chk("R2 transfer ends", int'(busy), 0);
    if (7'(addr) != SLV_ADDR) begin exp_done = 1; exp_err = 1; exp_wr = 0; end
    else if (!rd && nk >= 0 && nk < len) begin exp_done = nk + 2; exp_err = 1; exp_wr = nk + 1; end
    else begin exp_done = len + 1; exp_err = 0; exp_wr = rd ? 0 : len; end
    chk("R2 address byte", int'(slv_addr_byte), int'({7'(addr), rd}));
    chk("R2 one START", n_start - s0, 1);
    chk("R7 one STOP", n_stop - p0, 1);
    chk("R3 SCL high time", bad_hi, 0);
    chk("R11 byte_done count", done_cnt, exp_done);
    chk(exp_err ? "R7 bus_err set" : "R8 bus_err clear", int'(bus_err), int'(exp_err));
    chk("R9 irq", int'(irq), int'(exp_err && ie));
    if (!rd) begin
      chk("R5 bytes written", wr_cnt, exp_wr);
      for (int j = 0; j < exp_wr; j++) chk("R5 write data", int'(wr_got[j]), int'(wpat(addr, j)));
    end else if (exp_done > 1) begin
      chk("R6 master acks", m_ack, len - 1);
      chk("R8 master final nack", m_nack, 1);
    end
    if (bus_err) begin
      s0 = n_start;
      @(negedge clk); go = 1'b1; @(negedge clk); go = 1'b0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (busy) begin chk("R10 go ignored on error", 1, 0); break; end
      end
      chk("R10 no START while error", n_start - s0, 0);
      chk("R10 flag sticky", int'(bus_err), 1);
      err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
      chk("R10 flag cleared", int'(bus_err), 0);
      @(negedge clk);
      chk("R9 irq drops", int'(irq), 0);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int it;
    repeat (2) @(negedge clk);
    chk("R1 scl_oe in reset", int'(scl_oe), 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 byte_done", int'(byte_done), 0);
    chk("R1 bus_err", int'(bus_err), 0);
    chk("R1 irq", int'(irq), 0);
    it = 0;
    for (int rd = 0; rd < 2; rd++)
      for (int len = 0; len < 4; len++)
        for (int a = 0; a < 2; a++) begin
          run_xfer(a ? int'(SLV_ADDR ^ 7'h01) : int'(SLV_ADDR), rd[0], len, -1, it[0]);
          it++;
        end
    for (int nk = 0; nk < 3; nk++) begin
      run_xfer(int'(SLV_ADDR), 1'b0, 3, nk, nk[0]);
      run_xfer(int'(SLV_ADDR), 1'b0, 3, nk, ~nk[0]);
    end
    run_xfer(int'(SLV_ADDR), 1'b1, 5, -1, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule